// File: doc/BRIEF.md
# Grouped Two-Stage Interrupt Expander

This block gathers up to 96 interrupt sources, organised as 12 groups of 8, and presents them to a processor as a single request with a 7-bit vector index. Each source pulse is latched into a pending bit in its group. A group passes a request to its CPU line only when a pending bit is enabled and the group's service latch is clear. The CPU stage keeps a flag and an enable for each of the 12 lines. A global mask gates the final request.

Software reaches the block through a small write/read register port. Pending bits change only through per-bit set and per-bit clear writes, so a pulse from a source cannot be lost while software clears neighbouring bits. Software can set pending bits directly, which lets spare source slots act as software interrupts. When the CPU accepts a request, the block clears the serviced pending bit and the line flag, and latches the group as serviced. That group stays silent until software writes its release.

Top module: `irq_expander`

## Requirements
- R1: After reset, all pending bits, group enables, service latches, line flags and line enables are 0, the global mask reads 1, and `irq_req` is 0.
- R2: A one-cycle pulse on `src_irq[g*8+s]` sets pending bit s of group g. A second pulse while the bit is set merges into it, and one service clears it.
- R3: Write kind 0 (set) ORs `wr_data[7:0]` into the pending bits of group `wr_grp`. Write kind 1 (clear) clears the bits written 1 and leaves the bits written 0 untouched. A source pulse in the same cycle as a clear keeps its bit set.
- R4: A group raises its line flag only if a pending bit has its group enable set (write kind 2, read kind 1) and the group's service latch is 0. While the latch is 1 the line flag does not rise.
- R5: `irq_req` rises only when a line has its flag set and its enable set (write kind 4, read kind 4, bit g per line) and the global mask is 0 (write kind 5 with `wr_data[0]`, read kind 5).
- R6: Within a group the lowest-numbered enabled pending source wins. Across groups the lowest-numbered line wins.
- R7: When `irq_ack` is 1 while `irq_req` is 1, the serviced pending bit is cleared, the line flag (read kind 3) is cleared, and the group's service latch (read kind 2, bit 0) is set.
- R8: Write kind 3 with `wr_data[0]`=1 clears the group's service latch. If enabled bits are still pending, the line flag is set on the following cycle.
- R9: `irq_vec` equals g*8+s of the selected source and stays unchanged while `irq_req` is 1 until `irq_ack`, even when a higher-priority source arrives.
- R10: Reads are combinational. Read kind 0 returns the pending bits of `rd_grp`, and an out-of-range group number reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 96 | Source pulses, bit g*8+s |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write kind (0 set, 1 clear, 2 group enable, 3 release, 4 line enable, 5 mask) |
| wr_grp | input | 4 | Group number for group writes |
| wr_data | input | 12 | Write data |
| rd_sel | input | 3 | Read kind (0 pending, 1 group enable, 2 latch, 3 line flags, 4 line enables, 5 mask) |
| rd_grp | input | 4 | Group number for group reads |
| rd_data | output | 12 | Read data |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_vec | output | 7 | Vector index of the request |
| irq_ack | input | 1 | CPU service acknowledge |

## Verification
The hardest case to reach is a race between a software clear of a pending register and a source pulse on a bit of that same register, in the same clock cycle. The bench drives the clear strobe and the source pulse on one falling edge and then reads the register back. A second hard case is a higher-priority arrival while a vector is already held, which needs a request to stay outstanding on purpose while new pulses land. The bench also walks all 96 sources one at a time, from pulse through service to release.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  typedef enum logic [2:0] {
    WR_PEND_SET  = 3'd0,
    WR_PEND_CLR  = 3'd1,
    WR_GRP_EN    = 3'd2,
    WR_LATCH_REL = 3'd3,
    WR_LINE_EN   = 3'd4,
    WR_MASK      = 3'd5
  } wr_kind_e;

  typedef enum logic [2:0] {
    RD_PEND      = 3'd0,
    RD_GRP_EN    = 3'd1,
    RD_LATCH     = 3'd2,
    RD_LINE_FLAG = 3'd3,
    RD_LINE_EN   = 3'd4,
    RD_MASK      = 3'd5
  } rd_kind_e;

  // index of the lowest set bit among the first n bits (0 when none)
  function automatic int lowest_set(input logic [63:0] v, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // flat vector index of a source within a line
  function automatic int vec_index(input int line, input int src, input int per_line);
    return line * per_line + src;
  endfunction

endpackage

// File: rtl/irqx_group.sv
module irqx_group
  import irqx_pkg::*;
#(
  parameter int SRCS  = 8,
  parameter int SRC_W = $clog2(SRCS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRCS-1:0]  src,
  input  logic [SRCS-1:0]  set_bits,
  input  logic [SRCS-1:0]  clr_bits,
  input  logic             en_wr,
  input  logic [SRCS-1:0]  en_data,
  input  logic             latch_rel,
  input  logic             svc,
  input  logic [SRC_W-1:0] svc_src,
  output logic [SRCS-1:0]  pend_q,
  output logic [SRCS-1:0]  en_q,
  output logic             latch_q,
  output logic             grp_req,
  output logic [SRC_W-1:0] grp_sel,
  output logic             line_raise
);

  logic [SRCS-1:0] svc_mask;
  logic [SRCS-1:0] live;
  logic [SRCS-1:0] pend_nxt;

  always_comb begin
    svc_mask = '0;
    if (svc) svc_mask[svc_src] = 1'b1;
  end

  // sources win over any clear in the same cycle
  assign pend_nxt   = ((pend_q | set_bits) & ~(clr_bits | svc_mask)) | src;
  assign live       = pend_q & en_q;
  assign grp_req    = |live;
  assign grp_sel    = SRC_W'(lowest_set(64'(live), SRCS));
  assign line_raise = grp_req & ~latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      latch_q <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      if (en_wr) en_q <= en_data;
      if (svc)            latch_q <= 1'b1;
      else if (latch_rel) latch_q <= 1'b0;
    end
  end

  assert_src_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> ((pend_q & $past(src)) == $past(src)));

  assert_clear_spares_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_q) |=> ((($past(pend_q) & ~$past(clr_bits | svc_mask)) & ~pend_q) == '0));

  assert_latch_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> latch_q);

  assert_latch_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rel && !svc) |=> !latch_q);

endmodule

// File: rtl/irqx_cpu.sv
module irqx_cpu
  import irqx_pkg::*;
#(
  parameter int LINES  = 12,
  parameter int SRCS   = 8,
  parameter int SRC_W  = $clog2(SRCS),
  parameter int LINE_W = $clog2(LINES),
  parameter int VEC_W  = $clog2(LINES * SRCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line_raise,
  input  logic [LINES-1:0]  grp_req,
  input  logic [SRC_W-1:0]  grp_sel [LINES],
  input  logic              en_wr,
  input  logic [LINES-1:0]  en_data,
  input  logic              mask_wr,
  input  logic              mask_data,
  input  logic              irq_ack,
  output logic [LINES-1:0]  line_flag_q,
  output logic [LINES-1:0]  line_en_q,
  output logic              mask_q,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [LINES-1:0]  svc_vec,
  output logic [SRC_W-1:0]  svc_src
);

  logic [LINES-1:0]  cand;
  logic [LINE_W-1:0] cand_line;
  logic              cand_ok;
  logic              svc_fire;
  logic              req_q;
  logic [VEC_W-1:0]  vec_q;
  logic [LINE_W-1:0] line_q;
  logic [SRC_W-1:0]  src_q;

  assign cand      = line_flag_q & line_en_q & grp_req;
  assign cand_ok   = (|cand) && !mask_q;
  assign cand_line = LINE_W'(lowest_set(64'(cand), LINES));
  assign svc_fire  = req_q & irq_ack;
  assign irq_req   = req_q;
  assign irq_vec   = vec_q;
  assign svc_src   = src_q;

  always_comb begin
    svc_vec = '0;
    if (svc_fire) svc_vec[line_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_flag_q <= '0;
      line_en_q   <= '0;
      mask_q      <= 1'b1;
      req_q       <= 1'b0;
      vec_q       <= '0;
      line_q      <= '0;
      src_q       <= '0;
    end else begin
      line_flag_q <= (line_flag_q | line_raise) & ~svc_vec;
      if (en_wr)   line_en_q <= en_data;
      if (mask_wr) mask_q    <= mask_data;
      if (svc_fire) begin
        req_q <= 1'b0;
      end else if (!req_q && cand_ok) begin
        req_q  <= 1'b1;
        line_q <= cand_line;
        src_q  <= grp_sel[cand_line];
        vec_q  <= VEC_W'(vec_index(int'(cand_line), int'(grp_sel[cand_line]), SRCS));
      end
    end
  end

  assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !irq_ack) |=> (req_q && $stable(vec_q)));

  assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(mask_q));

  assert_line_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(|(line_flag_q & line_en_q)));

  assert_line_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |=> ((line_flag_q & $past(svc_vec)) == '0));

endmodule

// File: rtl/irq_expander.sv
module irq_expander
  import irqx_pkg::*;
#(
  parameter int LINES = 12,
  parameter int SRCS  = 8,
  localparam int NSRC   = LINES * SRCS,
  localparam int SRC_W  = $clog2(SRCS),
  localparam int GRP_W  = $clog2(LINES),
  localparam int VEC_W  = $clog2(NSRC),
  localparam int DATA_W = (LINES > SRCS) ? LINES : SRCS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  input  logic [GRP_W-1:0]  rd_grp,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack
);

  logic [SRCS-1:0]  pend   [LINES];
  logic [SRCS-1:0]  gen    [LINES];
  logic [SRC_W-1:0] gsel   [LINES];
  logic [LINES-1:0] latch_vec;
  logic [LINES-1:0] grp_req;
  logic [LINES-1:0] line_raise;
  logic [LINES-1:0] line_flag;
  logic [LINES-1:0] line_en;
  logic [LINES-1:0] svc_vec;
  logic [SRC_W-1:0] svc_src;
  logic             mask_q;

  for (genvar g = 0; g < LINES; g++) begin : g_grp
    logic            hit;
    logic [SRCS-1:0] set_b;
    logic [SRCS-1:0] clr_b;

    assign hit   = wr_en && (wr_grp == GRP_W'(g));
    assign set_b = (hit && wr_sel == WR_PEND_SET) ? wr_data[SRCS-1:0] : '0;
    assign clr_b = (hit && wr_sel == WR_PEND_CLR) ? wr_data[SRCS-1:0] : '0;

    irqx_group #(.SRCS(SRCS), .SRC_W(SRC_W)) u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (src_irq[g*SRCS +: SRCS]),
      .set_bits   (set_b),
      .clr_bits   (clr_b),
      .en_wr      (hit && wr_sel == WR_GRP_EN),
      .en_data    (wr_data[SRCS-1:0]),
      .latch_rel  (hit && wr_sel == WR_LATCH_REL && wr_data[0]),
      .svc        (svc_vec[g]),
      .svc_src    (svc_src),
      .pend_q     (pend[g]),
      .en_q       (gen[g]),
      .latch_q    (latch_vec[g]),
      .grp_req    (grp_req[g]),
      .grp_sel    (gsel[g]),
      .line_raise (line_raise[g])
    );

    assert_latch_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_flag[g]) |-> !$past(latch_vec[g]));
  end

  irqx_cpu #(
    .LINES (LINES),
    .SRCS  (SRCS),
    .SRC_W (SRC_W),
    .LINE_W(GRP_W),
    .VEC_W (VEC_W)
  ) u_cpu (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_raise (line_raise),
    .grp_req    (grp_req),
    .grp_sel    (gsel),
    .en_wr      (wr_en && wr_sel == WR_LINE_EN),
    .en_data    (wr_data[LINES-1:0]),
    .mask_wr    (wr_en && wr_sel == WR_MASK),
    .mask_data  (wr_data[0]),
    .irq_ack    (irq_ack),
    .line_flag_q(line_flag),
    .line_en_q  (line_en),
    .mask_q     (mask_q),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .svc_vec    (svc_vec),
    .svc_src    (svc_src)
  );

  // R10: combinational read mux, out-of-range groups read zero
  always_comb begin
    rd_data = '0;
    case (rd_sel)
      RD_PEND:      if (rd_grp < GRP_W'(LINES)) rd_data[SRCS-1:0] = pend[rd_grp];
      RD_GRP_EN:    if (rd_grp < GRP_W'(LINES)) rd_data[SRCS-1:0] = gen[rd_grp];
      RD_LATCH:     if (rd_grp < GRP_W'(LINES)) rd_data[0] = latch_vec[rd_grp];
      RD_LINE_FLAG: rd_data[LINES-1:0] = line_flag;
      RD_LINE_EN:   rd_data[LINES-1:0] = line_en;
      RD_MASK:      rd_data[0] = mask_q;
      default:      rd_data = '0;
    endcase
  end

  assert_one_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_vec & line_flag));

endmodule

// File: tb/irq_expander_bench.sv
module irq_expander_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src_irq = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [3:0]  wr_grp = '0;
  logic [11:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [3:0]  rd_grp = '0;
  logic [11:0] rd_data;
  logic        irq_req;
  logic [6:0]  irq_vec;
  logic        irq_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irq_expander u_irq_expander (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_grp(wr_grp), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_grp(rd_grp), .rd_data(rd_data),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int g, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_grp = 4'(g); wr_data = 12'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input int g, output int v);
    rd_sel = sel; rd_grp = 4'(g);
    #1;
    v = int'(rd_data);
  endtask

  task automatic pulse2(input int a, input int b);
    @(negedge clk);
    src_irq[a] = 1'b1; src_irq[b] = 1'b1;
    @(negedge clk);
    src_irq = '0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int v;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req", int'(irq_req), 0);
    rd(3'd5, 0, v); check("R1 mask", v, 1);
    rd(3'd4, 0, v); check("R1 line en", v, 0);
    rd(3'd3, 0, v); check("R1 line flag", v, 0);
    rd(3'd0, 0, v); check("R1 pend", v, 0);
    rd(3'd2, 0, v); check("R1 latch", v, 0);
    rd(3'd1, 5, v); check("R1 grp en", v, 0);

    wr(3'd5, 0, 0);
    wr(3'd4, 0, 12'hFFF);
    for (int g = 0; g < 12; g++) wr(3'd2, g, 8'hFF);

    // sweep all sources: R2 R5 R7 R8 R9
    for (int g = 0; g < 12; g++) begin
      for (int s = 0; s < 8; s++) begin
        pulse2(g*8+s, g*8+s);
        wait_n(3);
        check("R5 req", int'(irq_req), 1);
        check("R9 vec", int'(irq_vec), g*8+s);
        ack();
        check("R7 req drop", int'(irq_req), 0);
        rd(3'd0, g, v); check("R7 pend cleared", v, 0);
        rd(3'd2, g, v); check("R7 latch set", v, 1);
        rd(3'd3, 0, v); check("R7 line flag", (v >> g) & 1, 0);
        wr(3'd3, g, 1);
        rd(3'd2, g, v); check("R8 latch released", v, 0);
      end
    end

    // R6 within group, R4 latch block, R8 re-raise
    pulse2(29, 26);
    wait_n(3);
    check("R6 low source first", int'(irq_vec), 26);
    ack();
    wait_n(3);
    check("R4 latch blocks req", int'(irq_req), 0);
    rd(3'd3, 0, v); check("R4 line flag held low", (v >> 3) & 1, 0);
    wr(3'd3, 3, 1);
    rd(3'd3, 0, v); check("R8 not yet", (v >> 3) & 1, 0);
    wait_n(1);
    rd(3'd3, 0, v); check("R8 re-raised", (v >> 3) & 1, 1);
    wait_n(2);
    check("R6 next source", int'(irq_vec), 29);
    ack(); wr(3'd3, 3, 1);

    // R6 across lines, R9 hold
    pulse2(56, 22);
    wait_n(3);
    check("R6 low line first", int'(irq_vec), 22);
    pulse2(0, 0);
    wait_n(3);
    check("R9 held", int'(irq_vec), 22);
    check("R9 req held", int'(irq_req), 1);
    ack();
    wait_n(3);
    check("R6 line0", int'(irq_vec), 0);
    ack(); wr(3'd3, 0, 1); wr(3'd3, 2, 1);
    wait_n(3);
    check("R6 line7", int'(irq_vec), 56);
    ack(); wr(3'd3, 7, 1);

    // R2 merge, R5 global mask
    wr(3'd5, 0, 1);
    pulse2(40, 40);
    pulse2(40, 40);
    wait_n(3);
    check("R5 masked", int'(irq_req), 0);
    rd(3'd0, 5, v); check("R2 merged pend", v, 1);
    rd(3'd3, 0, v); check("R5 line flag", (v >> 5) & 1, 1);
    wr(3'd5, 0, 0);
    wait_n(2);
    check("R5 unmasked vec", int'(irq_vec), 40);
    ack(); wr(3'd3, 5, 1);
    wait_n(3);
    check("R2 single service", int'(irq_req), 0);

    // R5 line enable
    wr(3'd4, 0, 12'hFEF);
    pulse2(33, 33);
    wait_n(3);
    check("R5 line disabled", int'(irq_req), 0);
    rd(3'd3, 0, v); check("R5 flag set", (v >> 4) & 1, 1);
    wr(3'd4, 0, 12'hFFF);
    wait_n(2);
    check("R5 line enabled vec", int'(irq_vec), 33);
    ack(); wr(3'd3, 4, 1);

    // R4 group enable
    wr(3'd2, 6, 8'hFE);
    pulse2(48, 48);
    wait_n(3);
    check("R4 disabled source", int'(irq_req), 0);
    rd(3'd3, 0, v); check("R4 no line flag", (v >> 6) & 1, 0);
    rd(3'd0, 6, v); check("R4 pend kept", v, 1);
    wr(3'd1, 6, 8'h01);
    rd(3'd0, 6, v); check("R3 clear", v, 0);
    wr(3'd2, 6, 8'hFF);

    // R3 software interrupt
    wr(3'd0, 11, 8'h80);
    wait_n(3);
    check("R3 soft vec", int'(irq_vec), 95);
    ack(); wr(3'd3, 11, 1);

    // R3 clear racing a source pulse
    wr(3'd2, 9, 8'h00);
    wr(3'd0, 9, 8'h0D);
    @(negedge clk);
    src_irq[73] = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd1; wr_grp = 4'd9; wr_data = 12'h003;
    @(negedge clk);
    src_irq = '0; wr_en = 1'b0;
    rd(3'd0, 9, v); check("R3 race keeps source", v, 8'h0E);
    wr(3'd1, 9, 8'hFF);
    wr(3'd2, 9, 8'hFF);

    // R10 out-of-range group
    rd(3'd0, 14, v); check("R10 out of range", v, 0);

    done = 1'b1;
    finish_run();
  end

endmodule